// File: doc/BRIEF.md
# ATA PIO Bus Cycle Sequencer

This block turns a single host request into one programmed-I/O transfer on a parallel ATA device bus. The host presents a packed address/select word, a direction bit, a flag choosing the 8-bit register timing set or the 16-bit data-port timing set, and the write data. The block then walks the device bus through three phases. In setup, the address and chip selects are valid and both strobes are high. In active, the read or write strobe is low. In recovery, the strobe is high again while the address is still held.

All phase lengths come from clock-count inputs, so software can retune the bus for any transfer mode without touching the sequencer. When enabled, the device's ready line can stretch the active phase, and a fixed ceiling ends the wait. Recovery is sized from the cycle time that actually elapsed. Written data stays on the bus for a hold time that depends on the PIO mode. A one-clock done pulse closes each transfer and carries the read data.

Top module: `ata_pio_seq`

## Requirements
- R1: While reset is applied and whenever no transfer runs, both chip selects and both strobes are high, the bus output enable is low and done is low.
- R2: The select word maps bits [4:2] to the address lines, bit 1 to CS1N and bit 0 to CS0N. These outputs hold their values from the first setup cycle to the last recovery cycle. Setup lasts max(setup count, 1) cycles with both strobes high.
- R3: A read drives only DIOR- low and a write drives only DIOW- low. The two strobes are never low together.
- R4: With ready sampling disabled, active lasts max(active count, 1) cycles. The count is taken from the 8-bit set when the register flag is 1 and from the 16-bit set when it is 0.
- R5: With ready sampling enabled, the ready input passes through a two-flop synchronizer. Active ends on the first cycle whose 0-based index is at least active count − 1, at least IORDY_DLY, and in which the synchronized ready is high.
- R6: If ready stays low, active ends after max(active count, IORDY_MAX) cycles.
- R7: Let A be the number of active cycles that actually elapsed. Recovery lasts (cycle count − A) when that exceeds the recovery count of the selected set, and otherwise the recovery count. It never lasts less than 1 cycle.
- R8: Read data is captured on the clock edge that ends active, which is when DIOR- rises. It is shown on rdata with done and is kept until the next read completes.
- R9: During a write, the output enable is high for the whole active phase and for exactly H cycles after DIOW- rises. H is 3 for PIO mode 0, 2 for modes 1 and 2, and 1 for modes 3 and above. Write recovery is at least H. The output enable stays low during reads.
- R10: Done is high for exactly one cycle. That cycle directly follows the last recovery cycle, and in it the selects and strobes are already high.
- R11: A request raised while a transfer is in progress is ignored. It changes no bus output and starts no later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a transfer (taken only when idle) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_is_reg_i | input | 1 | 1 = 8-bit register timing, 0 = 16-bit data timing |
| req_sel_i | input | 5 | Packed word: address [4:2], CS1N [1], CS0N [0] |
| req_wdata_i | input | 16 | Write data |
| iordy_en_i | input | 1 | Enable ready-line wait states |
| pio_mode_i | input | 3 | PIO mode number, sets write hold |
| t_setup_i | input | 8 | Setup cycles |
| t_act8_i | input | 8 | Active cycles, register set |
| t_cyc8_i | input | 8 | Total cycle time, register set |
| t_rec8_i | input | 8 | Minimum recovery, register set |
| t_act16_i | input | 8 | Active cycles, data set |
| t_cyc16_i | input | 8 | Total cycle time, data set |
| t_rec16_i | input | 8 | Minimum recovery, data set |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| ata_addr_o | output | 3 | Device address lines |
| ata_cs0n_o | output | 1 | Chip select 0, active low |
| ata_cs1n_o | output | 1 | Chip select 1, active low |
| ata_diorn_o | output | 1 | Read strobe, active low |
| ata_diown_o | output | 1 | Write strobe, active low |
| ata_dd_i | input | 16 | Data bus input |
| ata_dd_o | output | 16 | Data bus output value |
| ata_dd_oe_o | output | 1 | Data bus output enable |
| ata_iordy_i | input | 1 | Device ready (asynchronous) |

## Verification
The bench places a different value on the data bus on each side of the DIOR- rise. A design that samples when the strobe falls, or one edge late, returns the wrong word. The ready line is raised at a chosen active cycle, held high from the start, and never raised. These cases expose a wrong synchronizer latency, a missing earliest-sample limit, and a missing timeout ceiling; each shows up as an active length off by cycles. Recovery is driven from both sides of the cycle-minus-active rule, a stretched active included, and with all-zero timing, so a design that uses the programmed active count instead of the elapsed one, or lets a zero count wrap, gives visibly wrong recovery lengths. Write hold is counted per PIO mode against a short recovery. A request is also poked in mid-transfer, which catches a design that restarts or relatches its select word.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  // packed select word: the MSB field lands on bits [4:2]
  typedef struct packed {
    logic [2:0] addr;
    logic       cs1n;
    logic       cs0n;
  } sel_word_t;

  localparam int HOLD_W = 2;

  // data hold after write strobe release, in clocks, per PIO mode
  function automatic logic [HOLD_W-1:0] hold_for_mode(input logic [2:0] mode);
    if (mode == 3'd0)      return 2'd3;
    else if (mode < 3'd3)  return 2'd2;
    else                   return 2'd1;
  endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= 1'b0;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int E_W   = 9
) (
  input  logic              is_reg_i,
  input  logic              is_write_i,
  input  logic [2:0]        pio_mode_i,
  input  logic [CNT_W-1:0]  t_setup_i,
  input  logic [CNT_W-1:0]  t_act8_i,
  input  logic [CNT_W-1:0]  t_cyc8_i,
  input  logic [CNT_W-1:0]  t_rec8_i,
  input  logic [CNT_W-1:0]  t_act16_i,
  input  logic [CNT_W-1:0]  t_cyc16_i,
  input  logic [CNT_W-1:0]  t_rec16_i,
  input  logic [E_W-1:0]    act_seen_i,
  output logic [CNT_W-1:0]  setup_len_o,
  output logic [CNT_W-1:0]  act_len_o,
  output logic [CNT_W-1:0]  rec_len_o,
  output logic [HOLD_W-1:0] hold_o
);

  localparam int PAD_W = E_W - CNT_W;
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [E_W-1:0]   E_ONE = E_W'(1);

  logic [CNT_W-1:0] act_sel, cyc_sel, rec_sel;
  logic [E_W-1:0]   cyc_x, rec_x, gap, pick, hold_x;

  always_comb begin
    act_sel = is_reg_i ? t_act8_i : t_act16_i;
    cyc_sel = is_reg_i ? t_cyc8_i : t_cyc16_i;
    rec_sel = is_reg_i ? t_rec8_i : t_rec16_i;

    setup_len_o = (t_setup_i == '0) ? C_ONE : t_setup_i;
    act_len_o   = (act_sel == '0) ? C_ONE : act_sel;

    cyc_x  = {{PAD_W{1'b0}}, cyc_sel};
    rec_x  = {{PAD_W{1'b0}}, rec_sel};
    hold_x = {{(E_W-HOLD_W){1'b0}}, hold_o};

    gap  = (cyc_x > act_seen_i) ? (cyc_x - act_seen_i) : '0;
    pick = (gap > rec_x) ? gap : rec_x;
    if (pick == '0) pick = E_ONE;
    if (is_write_i && (pick < hold_x)) pick = hold_x;
    rec_len_o = pick[CNT_W-1:0];
  end

  assign hold_o = hold_for_mode(pio_mode_i);

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int E_W       = 9,
  parameter int DATA_W    = 16,
  parameter int IORDY_DLY = 4,
  parameter int IORDY_MAX = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_is_reg_i,
  input  logic [4:0]        req_sel_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              iordy_en_i,
  input  logic              iordy_s_i,
  input  logic [DATA_W-1:0] dd_i,
  input  logic [CNT_W-1:0]  setup_len_i,
  input  logic [CNT_W-1:0]  act_len_i,
  input  logic [CNT_W-1:0]  rec_len_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              is_reg_o,
  output logic              is_write_o,
  output logic [E_W-1:0]    act_seen_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        addr_o,
  output logic              cs0n_o,
  output logic              cs1n_o,
  output logic              diorn_o,
  output logic              diown_o,
  output logic [DATA_W-1:0] dd_o,
  output logic              dd_oe_o
);

  localparam logic [E_W-1:0]    E_ONE  = E_W'(1);
  localparam logic [E_W-1:0]    E_DLY  = E_W'(IORDY_DLY);
  localparam logic [E_W-1:0]    E_LAST = E_W'(IORDY_MAX - 1);
  localparam logic [CNT_W-1:0]  C_ONE  = CNT_W'(1);
  localparam logic [HOLD_W-1:0] H_ONE  = HOLD_W'(1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [E_W-1:0]    elap_q, elap_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  sel_word_t         sel_q;
  logic              write_q, is_reg_q, done_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  logic             accept, leave_act, act_min_met, rdy_met;
  logic [E_W-1:0]   act_x;

  assign act_x = {{(E_W-CNT_W){1'b0}}, act_len_i};

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    elap_d    = elap_q;
    accept    = 1'b0;
    leave_act = 1'b0;

    act_min_met = (elap_q >= (act_x - E_ONE));
    rdy_met     = !iordy_en_i || (elap_q >= E_LAST) ||
                  ((elap_q >= E_DLY) && iordy_s_i);

    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept  = 1'b1;
          state_d = ST_SETUP;
          cnt_d   = setup_len_i - C_ONE;
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_ACTIVE;
          elap_d  = '0;
        end else begin
          cnt_d = cnt_q - C_ONE;
        end
      end
      ST_ACTIVE: begin
        if (act_min_met && rdy_met) begin
          leave_act = 1'b1;
          state_d   = ST_RECOVER;
          cnt_d     = rec_len_i - C_ONE;
        end else begin
          elap_d = elap_q + E_ONE;
        end
      end
      ST_RECOVER: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - C_ONE;
      end
      default: state_d = ST_IDLE;
    endcase

    hold_d = hold_q;
    if (leave_act && write_q)  hold_d = hold_i;
    else if (hold_q != '0)     hold_d = hold_q - H_ONE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      elap_q   <= '0;
      hold_q   <= '0;
      done_q   <= 1'b0;
      sel_q    <= '0;
      write_q  <= 1'b0;
      is_reg_q <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      elap_q  <= elap_d;
      hold_q  <= hold_d;
      done_q  <= (state_q == ST_RECOVER) && (state_d == ST_IDLE);
      if (accept) begin
        sel_q    <= sel_word_t'(req_sel_i);
        write_q  <= req_write_i;
        is_reg_q <= req_is_reg_i;
        wdata_q  <= req_wdata_i;
      end
      if (leave_act && !write_q) begin
        rdata_q <= dd_i;
      end
    end
  end

  // outputs decoded from registered state
  logic busy, strobe;
  assign busy   = (state_q != ST_IDLE);
  assign strobe = (state_q == ST_ACTIVE);

  assign addr_o     = busy ? sel_q.addr : 3'd0;
  assign cs1n_o     = busy ? sel_q.cs1n : 1'b1;
  assign cs0n_o     = busy ? sel_q.cs0n : 1'b1;
  assign diorn_o    = !(strobe && !write_q);
  assign diown_o    = !(strobe && write_q);
  assign dd_o       = wdata_q;
  assign dd_oe_o    = (strobe && write_q) || (hold_q != '0);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign is_reg_o   = is_reg_q;
  assign is_write_o = write_q;
  assign act_seen_o = elap_q + E_ONE;

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DATA_W      = 16,
  parameter int IORDY_DLY   = 4,
  parameter int IORDY_MAX   = 125,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              req_write_i,
  input  logic              req_is_reg_i,
  input  logic [4:0]        req_sel_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              iordy_en_i,
  input  logic [2:0]        pio_mode_i,
  input  logic [CNT_W-1:0]  t_setup_i,
  input  logic [CNT_W-1:0]  t_act8_i,
  input  logic [CNT_W-1:0]  t_cyc8_i,
  input  logic [CNT_W-1:0]  t_rec8_i,
  input  logic [CNT_W-1:0]  t_act16_i,
  input  logic [CNT_W-1:0]  t_cyc16_i,
  input  logic [CNT_W-1:0]  t_rec16_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [2:0]        ata_addr_o,
  output logic              ata_cs0n_o,
  output logic              ata_cs1n_o,
  output logic              ata_diorn_o,
  output logic              ata_diown_o,
  input  logic [DATA_W-1:0] ata_dd_i,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe_o,
  input  logic              ata_iordy_i
);

  localparam int WAIT_W = $clog2(IORDY_MAX + 1);
  localparam int E_W    = ((CNT_W > WAIT_W) ? CNT_W : WAIT_W) + 1;

  logic              rst_n_int, iordy_s;
  logic              is_reg, is_write;
  logic [E_W-1:0]    act_seen;
  logic [CNT_W-1:0]  setup_len, act_len, rec_len;
  logic [HOLD_W-1:0] hold_len;

  // reset: asserted asynchronously, released on a clock edge
  ata_pio_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_n_int)
  );

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_iordy_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (ata_iordy_i),
    .q_o   (iordy_s)
  );

  ata_pio_timing #(.CNT_W(CNT_W), .E_W(E_W)) u_timing (
    .is_reg_i    (is_reg),
    .is_write_i  (is_write),
    .pio_mode_i  (pio_mode_i),
    .t_setup_i   (t_setup_i),
    .t_act8_i    (t_act8_i),
    .t_cyc8_i    (t_cyc8_i),
    .t_rec8_i    (t_rec8_i),
    .t_act16_i   (t_act16_i),
    .t_cyc16_i   (t_cyc16_i),
    .t_rec16_i   (t_rec16_i),
    .act_seen_i  (act_seen),
    .setup_len_o (setup_len),
    .act_len_o   (act_len),
    .rec_len_o   (rec_len),
    .hold_o      (hold_len)
  );

  ata_pio_fsm #(
    .CNT_W     (CNT_W),
    .E_W       (E_W),
    .DATA_W    (DATA_W),
    .IORDY_DLY (IORDY_DLY),
    .IORDY_MAX (IORDY_MAX)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .req_i        (req_i),
    .req_write_i  (req_write_i),
    .req_is_reg_i (req_is_reg_i),
    .req_sel_i    (req_sel_i),
    .req_wdata_i  (req_wdata_i),
    .iordy_en_i   (iordy_en_i),
    .iordy_s_i    (iordy_s),
    .dd_i         (ata_dd_i),
    .setup_len_i  (setup_len),
    .act_len_i    (act_len),
    .rec_len_i    (rec_len),
    .hold_i       (hold_len),
    .is_reg_o     (is_reg),
    .is_write_o   (is_write),
    .act_seen_o   (act_seen),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .addr_o       (ata_addr_o),
    .cs0n_o       (ata_cs0n_o),
    .cs1n_o       (ata_cs1n_o),
    .diorn_o      (ata_diorn_o),
    .diown_o      (ata_diown_o),
    .dd_o         (ata_dd_o),
    .dd_oe_o      (ata_dd_oe_o)
  );

endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk #(
  parameter int CNT_W     = 8,
  parameter int IORDY_MAX = 125
) (
  input logic       clk,
  input logic       rst_n,
  input logic       done_o,
  input logic [2:0] ata_addr_o,
  input logic       ata_cs0n_o,
  input logic       ata_cs1n_o,
  input logic       ata_diorn_o,
  input logic       ata_diown_o,
  input logic       ata_dd_oe_o
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int LIM     = (CNT_MAX > IORDY_MAX) ? CNT_MAX : IORDY_MAX;
  localparam int LW      = $clog2(LIM + 2) + 1;

  logic          stb_low;
  logic [LW-1:0] low_run;

  assign stb_low = !ata_diorn_o || !ata_diown_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_run <= '0;
    else if (stb_low) low_run <= low_run + LW'(1);
    else              low_run <= '0;
  end

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_diorn_o && !ata_diown_o));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_low || $past(stb_low)) |-> $stable({ata_addr_o, ata_cs1n_o, ata_cs0n_o}));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ata_cs0n_o && ata_cs1n_o && ata_diorn_o && ata_diown_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_write_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diown_o |-> ata_dd_oe_o);

  p_read_no_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_diorn_o |-> !ata_dd_oe_o);

  p_active_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LW'(LIM));

endmodule

bind ata_pio_seq ata_pio_chk #(.CNT_W(CNT_W), .IORDY_MAX(IORDY_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .ata_addr_o  (ata_addr_o),
  .ata_cs0n_o  (ata_cs0n_o),
  .ata_cs1n_o  (ata_cs1n_o),
  .ata_diorn_o (ata_diorn_o),
  .ata_diown_o (ata_diown_o),
  .ata_dd_oe_o (ata_dd_oe_o)
);

// File: tb/tb_ata_pio_seq.sv
module tb_ata_pio_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 4;
  localparam int MAXW       = 125;

  logic        clk, rst_n;
  logic        req_i, req_write_i, req_is_reg_i, iordy_en_i, ata_iordy_i;
  logic [4:0]  req_sel_i;
  logic [15:0] req_wdata_i, ata_dd_i;
  logic [2:0]  pio_mode_i;
  logic [7:0]  t_setup, t_act8, t_cyc8, t_rec8, t_act16, t_cyc16, t_rec16;
  logic        done_o, ata_cs0n_o, ata_cs1n_o, ata_diorn_o, ata_diown_o, ata_dd_oe_o;
  logic [15:0] rdata_o, ata_dd_o;
  logic [2:0]  ata_addr_o;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [15:0] last_rd;

  ata_pio_seq #(.CNT_W(8), .DATA_W(16), .IORDY_DLY(DLY), .IORDY_MAX(MAXW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_write_i(req_write_i),
    .req_is_reg_i(req_is_reg_i), .req_sel_i(req_sel_i), .req_wdata_i(req_wdata_i),
    .iordy_en_i(iordy_en_i), .pio_mode_i(pio_mode_i), .t_setup_i(t_setup),
    .t_act8_i(t_act8), .t_cyc8_i(t_cyc8), .t_rec8_i(t_rec8), .t_act16_i(t_act16),
    .t_cyc16_i(t_cyc16), .t_rec16_i(t_rec16), .done_o(done_o), .rdata_o(rdata_o),
    .ata_addr_o(ata_addr_o), .ata_cs0n_o(ata_cs0n_o), .ata_cs1n_o(ata_cs1n_o),
    .ata_diorn_o(ata_diorn_o), .ata_diown_o(ata_diown_o), .ata_dd_i(ata_dd_i),
    .ata_dd_o(ata_dd_o), .ata_dd_oe_o(ata_dd_oe_o), .ata_iordy_i(ata_iordy_i)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int hold_exp(input int mode);
    if (mode == 0) return 3;
    else if (mode < 3) return 2;
    else return 1;
  endfunction

  task automatic check_idle(input string rq);
    chk(ata_cs0n_o && ata_cs1n_o && ata_diorn_o && ata_diown_o, rq, "idle pins high",
        {ata_cs1n_o, ata_cs0n_o, ata_diorn_o, ata_diown_o}, 15);
    chk(!ata_dd_oe_o && !done_o, rq, "idle oe/done low", {ata_dd_oe_o, done_o}, 0);
  endtask

  // imode: 0 ready ignored, 1 ready high, 2 ready low then raised at active cycle rise_at (0 = never)
  task automatic run_cycle(input bit wr, input bit isreg, input logic [4:0] sel,
                           input logic [15:0] val, input int imode, input int rise_at,
                           input bit poke_busy, input string rq_act);
    int a_len, c_len, r_len, s_exp, a_exp, r_exp, w_exp, tmp, gap;
    int s_n, a_n, r_n, h_n, guard;
    bit seen, sel_bad, stb_bad, oe_bad, quiet_bad;
    s_n = 0; a_n = 0; r_n = 0; h_n = 0; guard = 0;
    seen = 0; sel_bad = 0; stb_bad = 0; oe_bad = 0; quiet_bad = 0;

    a_len = isreg ? int'(t_act8) : int'(t_act16);
    c_len = isreg ? int'(t_cyc8) : int'(t_cyc16);
    r_len = isreg ? int'(t_rec8) : int'(t_rec16);
    if (a_len == 0) a_len = 1;
    s_exp = (t_setup == 0) ? 1 : int'(t_setup);
    if (imode == 0)      a_exp = a_len;
    else if (imode == 1) a_exp = imax(a_len, DLY + 1);
    else if (rise_at == 0) a_exp = imax(a_len, MAXW);
    else begin
      tmp = imax(DLY + 1, rise_at + 2);
      if (tmp > MAXW) tmp = MAXW;
      a_exp = imax(a_len, tmp);
    end
    gap   = (c_len > a_exp) ? c_len - a_exp : 0;
    r_exp = imax(gap, r_len);
    if (r_exp == 0) r_exp = 1;
    w_exp = hold_exp(int'(pio_mode_i));
    if (wr && r_exp < w_exp) r_exp = w_exp;

    iordy_en_i  = (imode != 0);
    ata_iordy_i = (imode == 1);
    repeat (4) @(negedge clk);
    ata_dd_i     = 16'hDEAD;
    req_write_i  = wr;
    req_is_reg_i = isreg;
    req_sel_i    = sel;
    req_wdata_i  = val;
    req_i        = 1'b1;
    @(negedge clk);
    req_i = 1'b0;

    while (!done_o && guard < 3000) begin
      if (!ata_diorn_o || !ata_diown_o) begin
        seen = 1; a_n++;
        if (wr ? (ata_diown_o || !ata_diorn_o) : (ata_diorn_o || !ata_diown_o)) stb_bad = 1;
        if (wr && (!ata_dd_oe_o || ata_dd_o != val)) oe_bad = 1;
        if (!wr && ata_dd_oe_o) oe_bad = 1;
        if (a_n == 1) ata_dd_i = val;
        if (imode == 2 && rise_at != 0 && a_n == rise_at) ata_iordy_i = 1'b1;
        if (poke_busy && a_n == 1) begin req_i = 1'b1; req_sel_i = ~sel; end
        else if (poke_busy && a_n == 2) req_i = 1'b0;
      end else if (!seen) begin
        s_n++;
      end else begin
        r_n++;
        if (r_n == 1) ata_dd_i = ~val;
        if (ata_dd_oe_o) h_n++;
      end
      if ({ata_addr_o, ata_cs1n_o, ata_cs0n_o} != sel) sel_bad = 1;
      @(negedge clk);
      guard++;
    end
    req_i = 1'b0;

    chk(guard < 3000, "R10", "done reached", guard, 0);
    chk(s_n == s_exp, "R2", "setup cycles", s_n, s_exp);
    chk(!sel_bad, "R2", "select word held", int'(sel_bad), 0);
    chk(!stb_bad, "R3", "strobe choice", int'(stb_bad), 0);
    chk(a_n == a_exp, rq_act, "active cycles", a_n, a_exp);
    chk(r_n == r_exp, "R7", "recovery cycles", r_n, r_exp);
    chk(!oe_bad, "R9", "output enable in active", int'(oe_bad), 0);
    if (wr) chk(h_n == w_exp, "R9", "write hold cycles", h_n, w_exp);
    else begin
      chk(rdata_o == val, "R8", "read capture at strobe rise", int'(rdata_o), int'(val));
      last_rd = val;
    end
    chk(ata_cs0n_o && ata_cs1n_o && ata_diorn_o && ata_diown_o, "R10", "pins high with done",
        {ata_cs1n_o, ata_cs0n_o, ata_diorn_o, ata_diown_o}, 15);
    @(negedge clk);
    chk(!done_o, "R10", "done single cycle", int'(done_o), 0);
    if (poke_busy) begin
      for (int k = 0; k < 6; k++) begin
        if (!ata_cs0n_o || !ata_cs1n_o || !ata_diorn_o || !ata_diown_o || done_o) quiet_bad = 1;
        @(negedge clk);
      end
      chk(!quiet_bad, "R11", "request during transfer ignored", int'(quiet_bad), 0);
    end
    iordy_en_i  = 1'b0;
    ata_iordy_i = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 0; req_write_i = 0; req_is_reg_i = 0; req_sel_i = '0;
    req_wdata_i = '0; iordy_en_i = 0; ata_iordy_i = 1; ata_dd_i = '0; pio_mode_i = 3'd0;
    t_setup = 8'd2; t_act8 = 8'd3; t_cyc8 = 8'd12; t_rec8 = 8'd2;
    t_act16 = 8'd5; t_cyc16 = 8'd6; t_rec16 = 8'd4;
    last_rd = '0;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1");

    // register read, command block status (R4 8-bit set, R7 cycle minus active wins)
    run_cycle(1'b0, 1'b1, {3'd7, 1'b1, 1'b0}, 16'h00A5, 0, 0, 1'b0, "R4");
    // data read, 16-bit set, minimum recovery wins (R4, R7)
    run_cycle(1'b0, 1'b0, {3'd0, 1'b1, 1'b0}, 16'h1234, 0, 0, 1'b0, "R4");
    // control register write, mode 0, hold stretches recovery (R9)
    t_act8 = 8'd3; t_cyc8 = 8'd4; t_rec8 = 8'd1; pio_mode_i = 3'd0;
    run_cycle(1'b1, 1'b1, {3'd6, 1'b0, 1'b1}, 16'h00C3, 0, 0, 1'b0, "R4");
    // data writes in modes 2 and 4 (R9)
    pio_mode_i = 3'd2;
    run_cycle(1'b1, 1'b0, {3'd0, 1'b1, 1'b0}, 16'hBEEF, 0, 0, 1'b0, "R4");
    pio_mode_i = 3'd4;
    run_cycle(1'b1, 1'b0, {3'd0, 1'b1, 1'b0}, 16'h5AA5, 0, 0, 1'b0, "R4");
    check_idle("R9");
    chk(rdata_o == last_rd, "R8", "read data kept across writes", int'(rdata_o), int'(last_rd));
    // ready handling (R5, R6)
    t_act16 = 8'd2; t_cyc16 = 8'd20; t_rec16 = 8'd3;
    run_cycle(1'b0, 1'b0, {3'd0, 1'b1, 1'b0}, 16'h0F0F, 1, 0, 1'b0, "R5");
    run_cycle(1'b0, 1'b0, {3'd0, 1'b1, 1'b0}, 16'hF00F, 2, 10, 1'b0, "R5");
    run_cycle(1'b0, 1'b0, {3'd0, 1'b1, 1'b0}, 16'h3C3C, 2, 0, 1'b0, "R6");
    // all-zero timing clamps to one cycle each (R2, R4, R7)
    t_setup = 8'd0; t_act8 = 8'd0; t_cyc8 = 8'd0; t_rec8 = 8'd0;
    run_cycle(1'b0, 1'b1, {3'd1, 1'b1, 1'b0}, 16'h0077, 0, 0, 1'b0, "R4");
    // request poked mid-transfer (R11)
    t_setup = 8'd1; t_act16 = 8'd5; t_cyc16 = 8'd6; t_rec16 = 8'd2;
    run_cycle(1'b0, 1'b0, {3'd0, 1'b1, 1'b0}, 16'h8421, 0, 0, 1'b1, "R4");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule